// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves an incoming byte stream into memory. Frames arrive one byte per transfer on a valid/ready stream, with a start marker on the first byte and an end marker on the last. For each buffer the block first reads the descriptor at the current ring position and checks whether software still owns it. If the buffer is free, the block writes the bytes into it, packed little-endian into 32-bit words. It then writes the descriptor back with the byte count and the frame-boundary flags, and finally sets the ownership bit to hand the buffer to software.

Descriptors are two 32-bit words placed 8 bytes apart, starting at a ring base address. A frame longer than one buffer (BUF_BYTES, 1536 by default, a multiple of 4) continues into the next descriptor. The memory port accepts every request in the cycle it is made and returns read data one cycle later. Stream back-pressure works as follows. `s_ready` is low while a descriptor is fetched or written back. In idle, `s_ready` depends only on `s_sof` and `rx_en`, never on `s_valid`. A byte moves when `s_valid` and `s_ready` are both high at a rising edge.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset the block issues no memory request, `bna` is low, and `s_ready` is high while `s_sof` is low.
- R2: Before storing a frame the block reads word 0 of the current descriptor. If its bit 0 (owned) is 1, `bna` pulses for one cycle and the frame's bytes up to and including the end marker are accepted and discarded. In that case no buffer or descriptor is written, and the next frame again uses the same descriptor.
- R3: Byte k of a buffer is written at address (word 0 bits 31:2, times 4) + k. It goes to byte lane k mod 4 of a 32-bit little-endian word. Byte enables cover lanes 0 through k mod 4.
- R4: A filled buffer has descriptor word 1 written first and word 0 written second, in consecutive cycles. Word 1 holds the buffer's byte count in bits 13:0, a first-buffer flag in bit 14 and a last-buffer flag in bit 15, with all other bits zero. Word 0 keeps its address and bit 1 (wrap) and has bit 0 set.
- R5: A frame longer than BUF_BYTES fills whole buffers and places the remainder in further descriptors. Only the first descriptor has bit 14 set, and only the last has bit 15 set.
- R6: After a descriptor is written back, the ring position moves forward 8 bytes if its bit 1 was 0, and returns to `ring_base` if it was 1.
- R7: `rx_en` is sampled only when a frame starts. If it is low at that point, the whole frame is accepted and discarded with no memory access. Clearing it during a frame lets that frame complete normally.
- R8: Bytes that arrive while idle without the start marker are accepted and discarded without any memory access.
- R9: When a start byte is presented in idle with `rx_en` high, `s_ready` is low until the descriptor fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| ring_base | input | AW | Byte address of the first descriptor |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| bna | output | 1 | One-cycle pulse: descriptor still owned by software |

## Verification
The test stream uses several frame lengths, and each pattern separates a different behaviour:
- A single byte and lengths that stop partway through a word show whether partial-word lane enables are correct.
- Exactly one buffer and one byte over show whether the buffer-boundary split and the flag placement are right.
- Several buffers in one frame show whether the first and last flags land on the right descriptors.

Running enough frames to go around the ring more than once tests the wrap path. Further directed cases cover:
- a descriptor that software still owns;
- stray bytes between frames;
- a frame arriving while receive is disabled;
- receive being disabled partway through a frame.

Each of these is judged by the memory writes seen at the port.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_DATA, S_WD1, S_WD0, S_DROP
  } rxd_state_e;

  // descriptor word 0
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  // descriptor word 1
  localparam int LEN_W    = 14;
  localparam int DESC_STRIDE = 8;
endpackage

// File: rtl/rxd_lane_pack.sv
module rxd_lane_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] word,
  output logic [3:0]  be
);
  logic [31:0] acc;

  assign word = ((lane == 2'd0) ? 32'd0 : acc) | (32'(din) << {lane, 3'b000});
  assign be   = 4'((5'd2 << lane) - 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (take) acc <= word;
  end

  // lanes fill in order, or restart at zero for a new buffer
  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (lane == $past(lane) + 2'd1) || (lane == 2'd0)); // R3
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  import rxd_pkg::*;

  logic          at_base;
  logic [AW-1:0] nxt_q;

  assign ptr = at_base ? base : nxt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      at_base <= 1'b1;
      nxt_q   <= '0;
    end else if (adv) begin
      if (wrap) begin
        at_base <= 1'b1;
      end else begin
        at_base <= 1'b0;
        nxt_q   <= ptr + AW'(DESC_STRIDE);
      end
    end
  end

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wrap |=> ptr == $past(ptr) + AW'(DESC_STRIDE)); // R6
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && wrap |=> ptr == base); // R6
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [AW-1:0] ring_base,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          bna
);
  import rxd_pkg::*;

  localparam int CW = $clog2(BUF_BYTES + 1);

  rxd_state_e    st;
  logic [CW-1:0] cnt;
  logic          first_q, ended_q;
  logic [31:0]   d0_q;
  logic [AW-1:0] buf_addr, ptr;
  logic          take, last_in_buf, word_wr, adv;
  logic [31:0]   pk_word;
  logic [3:0]    pk_be;

  assign take        = (st == S_DATA) && s_valid;
  assign last_in_buf = (cnt == CW'(BUF_BYTES - 1));
  assign word_wr     = take && ((cnt[1:0] == 2'd3) || s_eof || last_in_buf);
  assign adv         = (st == S_WD0);

  rxd_lane_pack u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .lane(cnt[1:0]),
    .din(s_data), .word(pk_word), .be(pk_be)
  );

  rxd_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base(ring_base), .adv(adv),
    .wrap(d0_q[WRAP_BIT]), .ptr(ptr)
  );

  always_comb begin
    s_ready   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 4'h0;
    mem_wdata = '0;
    bna       = 1'b0;
    unique case (st)
      S_IDLE:  s_ready = !(rx_en && s_sof);
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr;
      end
      S_CHECK: bna = mem_rdata[OWN_BIT];
      S_DATA: begin
        s_ready   = 1'b1;
        mem_req   = word_wr;
        mem_we    = word_wr;
        mem_addr  = buf_addr + AW'({cnt[CW-1:2], 2'b00});
        mem_be    = pk_be;
        mem_wdata = pk_word;
      end
      S_WD1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + AW'(4);
        mem_be    = 4'hF;
        mem_wdata = 32'({ended_q, first_q, LEN_W'(cnt)});
      end
      S_WD0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr;
        mem_be    = 4'hF;
        mem_wdata = d0_q | 32'(1 << OWN_BIT);
      end
      S_DROP:  s_ready = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      first_q  <= 1'b0;
      ended_q  <= 1'b0;
      d0_q     <= '0;
      buf_addr <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (s_valid && s_sof && rx_en) begin
          first_q <= 1'b1;
          st      <= S_FETCH;
        end
        S_FETCH: st <= S_CHECK;
        S_CHECK: begin
          if (mem_rdata[OWN_BIT]) begin
            st <= S_DROP;
          end else begin
            d0_q     <= mem_rdata;
            buf_addr <= AW'({mem_rdata[31:2], 2'b00});
            cnt      <= '0;
            st       <= S_DATA;
          end
        end
        S_DATA: if (take) begin
          cnt <= cnt + CW'(1);
          if (s_eof || last_in_buf) begin
            ended_q <= s_eof;
            st      <= S_WD1;
          end
        end
        S_WD1: st <= S_WD0;
        S_WD0: begin
          first_q <= 1'b0;
          st      <= ended_q ? S_IDLE : S_FETCH;
        end
        S_DROP: if (s_valid && s_eof) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BNA_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bna |-> $past(mem_req && !mem_we)); // R2
  AST_WB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WD0) |-> $past(mem_req && mem_we) && ($past(mem_addr) == ptr + AW'(4))); // R4
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> cnt < CW'(BUF_BYTES)); // R5
  AST_NO_WRITE_AFTER_BNA: assert property (@(posedge clk) disable iff (!rst_n)
    bna |=> !mem_req); // R2
endmodule

// File: tb/tb_rxd_ring_writer.sv
`timescale 1ns/1ps
module tb_rxd_ring_writer;
  localparam int BUF = 8;
  localparam int NV  = 8;
  localparam int FLEN [NV] = '{1, 4, 5, 8, 9, 16, 3, 20};
  localparam int NBUF [NV] = '{1, 1, 1, 1, 2, 2, 1, 3};

  logic clk = 0, rst_n = 0, rx_en = 1;
  logic [31:0] ring_base = 32'h0;
  logic s_valid = 0, s_sof = 0, s_eof = 0;
  logic [7:0] s_data = 0;
  logic s_ready, mem_req, mem_we, bna;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic [3:0] mem_be;

  logic [31:0] mem [0:255];
  logic sw_we = 0;
  logic [7:0] sw_idx = 0;
  logic [31:0] sw_data = 0;
  int wr_cnt = 0, bna_cnt = 0;
  int checks = 0, fails = 0;
  bit done = 0, first_rdy;
  int exp_idx = 0;

  always #2 clk = ~clk;

  rxd_ring_writer #(.AW(32), .BUF_BYTES(BUF)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof),
    .s_eof(s_eof), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .bna(bna)
  );

  always @(posedge clk) begin
    if (sw_we) mem[sw_idx] <= sw_data;
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (bna) bna_cnt <= bna_cnt + 1;
  end

  function automatic logic [31:0] w0_init(int d);
    return 32'h100 + 32'(d * 16) + ((d == 3) ? 32'h2 : 32'h0);
  endfunction

  function automatic logic [7:0] rd_byte(logic [31:0] a);
    logic [31:0] w;
    w = mem[a[9:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1; sw_idx = 8'(idx); sw_data = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic send(input int len, input int seed, input bit with_sof, input bit drop_en);
    for (int j = 0; j < len; j++) begin
      s_valid = 1; s_data = 8'(seed + j);
      s_sof = with_sof && (j == 0); s_eof = (j == len - 1);
      #1;
      if (j == 0) first_rdy = s_ready;
      while (!s_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      if (drop_en && j == 1) rx_en = 0;
    end
    s_valid = 0; s_sof = 0; s_eof = 0;
    repeat (12) @(negedge clk);
  endtask

  // check a stored frame against the ring model, then give its buffers back
  task automatic verify_frame(input int len, input int seed, input int nbuf, input string req);
    int remain = len, off = 0;
    for (int k = 0; k < nbuf; k++) begin
      int n = (remain < BUF) ? remain : BUF;
      logic [31:0] e1, w1, w0;
      bit data_ok = 1;
      e1 = 32'(n) | ((k == 0) ? 32'h4000 : 0) | ((k == nbuf - 1) ? 32'h8000 : 0);
      w0 = mem[exp_idx * 2];
      w1 = mem[exp_idx * 2 + 1];
      chk(w1 == e1, {req, " R4 R5 word1"}, w1, e1);
      chk(w0 == (w0_init(exp_idx) | 1), {req, " R4 word0"}, w0, w0_init(exp_idx) | 1);
      for (int j = 0; j < n; j++)
        if (rd_byte(32'h100 + 32'(exp_idx * 16 + j)) != 8'(seed + off + j)) data_ok = 0;
      chk(data_ok, {req, " R3 data"}, 32'(exp_idx), 32'(off));
      sw_write(exp_idx * 2, w0_init(exp_idx));
      sw_write(exp_idx * 2 + 1, 32'h0);
      exp_idx = (exp_idx + 1) % 4;   // R6 ring model
      remain -= n; off += n;
    end
  endtask

  initial begin
    int w_before, b_before;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int d = 0; d < 4; d++) mem[d * 2] = w0_init(d);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    chk(bna == 0, "R1 bna", 32'(bna), 0);
    chk(s_ready == 1, "R1 s_ready", 32'(s_ready), 1);
    rst_n = 1;
    @(negedge clk);

    // vector table, wraps the ring three times (R6)
    for (int v = 0; v < NV; v++) begin
      send(FLEN[v], v * 37 + 1, 1, 0);
      chk(first_rdy == 0, "R9 stall at start", 32'(first_rdy), 0);
      verify_frame(FLEN[v], v * 37 + 1, NBUF[v], "vec");
    end

    // R8: stray bytes without start marker
    w_before = wr_cnt;
    send(3, 90, 0, 0);
    chk(wr_cnt == w_before, "R8 no writes", 32'(wr_cnt), 32'(w_before));

    // R7: disabled at frame start
    rx_en = 0;
    w_before = wr_cnt;
    send(5, 50, 1, 0);
    chk(wr_cnt == w_before, "R7 disabled no writes", 32'(wr_cnt), 32'(w_before));
    chk(first_rdy == 1, "R7 accepted", 32'(first_rdy), 1);
    rx_en = 1;

    // R7: disabled mid-frame, frame completes
    send(12, 70, 1, 1);
    verify_frame(12, 70, 2, "R7 midframe");
    rx_en = 1;

    // R2: owned descriptor
    sw_write(exp_idx * 2, w0_init(exp_idx) | 1);
    sw_write(64 + exp_idx * 4, 32'hDEADBEEF);
    w_before = wr_cnt; b_before = bna_cnt;
    send(6, 20, 1, 0);
    chk(bna_cnt == b_before + 1, "R2 bna pulse", 32'(bna_cnt), 32'(b_before + 1));
    chk(wr_cnt == w_before, "R2 no writes", 32'(wr_cnt), 32'(w_before));
    chk(mem[64 + exp_idx * 4] == 32'hDEADBEEF, "R2 buffer intact",
        mem[64 + exp_idx * 4], 32'hDEADBEEF);
    sw_write(exp_idx * 2, w0_init(exp_idx));
    send(3, 200, 1, 0);
    verify_frame(3, 200, 1, "R2 same descriptor");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule